// File: doc/BRIEF.md
# Tapped Delay Line with Synchronous Load and Advance

This block is a parameterised shift-register delay line for a signed fixed-width sample stream. Each clock in which the advance control is active moves one new sample into the line. All delayed copies of the stream appear at once on a single flat output vector. Element `i` of that vector occupies bits `[i*W +: W]`. A synchronous load control writes a compile-time initial value into every tap. The load control wins over the advance control.

Compile-time parameters set the number of taps `N` and the data width `W`. Further parameters select whether element 0 is the oldest or the newest sample, and whether the undelayed input is added at the newest end of the vector. The output is meant for filter, correlator or resampling datapaths that need the whole sample history at once. The asynchronous active-low reset puts the line in the same initial-value state as the synchronous load. Simulation therefore starts from a defined state.

Top module: `tapped_delay_line`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, every tap presents `INIT_VAL`.
- R2: When `load_i` is nonzero at a rising clock edge, every tap holds `INIT_VAL` after that edge, whatever `adv_i` is.
- R3: When `load_i` is zero and `adv_i` is nonzero at a rising edge, the tap with delay 1 takes `din`, and the tap with delay k takes the previous value of the tap with delay k-1.
- R4: When `load_i` and `adv_i` are both zero at a rising edge, every tap keeps its value, so the output vector is unchanged.
- R5: With `NEWEST_FIRST = 0`, element i (for i < N) carries the tap with delay N-i: element 0 holds the oldest sample and element N-1 holds the delay-1 sample.
- R6: With `NEWEST_FIRST = 1`, element i (for i < N) carries the tap with delay i+1: element 0 holds the delay-1 sample and element N-1 holds the delay-N sample.
- R7: With `ADD_CURRENT = 1`, the vector has N+1 elements, and the undelayed `din` appears combinationally in the same cycle at the newest end. That is element N for oldest-first order and element 0 for newest-first order, with the taps shifted up by one element.
- R8: Any nonzero value on the multi-bit `load_i` or `adv_i` counts as active, including values with only the upper bit set.
- R9: Samples are signed `W`-bit values, and negative values pass through the line unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset; taps take `INIT_VAL` |
| load_i | input | CTRL_W | Synchronous load of `INIT_VAL` into all taps; active when nonzero |
| adv_i | input | CTRL_W | Advance the line by one sample; active when nonzero |
| din | input | W | Signed input sample |
| taps_o | output | OUT_N*W | Flat vector of delayed samples, element i at bits [i*W +: W] |

## Verification
Every tap is one register stage. A load or advance applied before a rising edge therefore shows on `taps_o` right after that edge. A sample entering on `din` reaches the delay-k element after k active advances. The added current-input element follows `din` in the same cycle, without any edge. The bench drives its inputs just after the falling edge, and it compares all four ordering and current-input variants against a queue model shortly after the inputs settle. Those comparisons therefore cover both the registered results of the previous edge and the same-cycle pass-through. The model is updated only at the rising edge, using the control values that the design saw.

// File: rtl/tdl_pkg.sv
package tdl_pkg;

  // Selected arrangement of the output vector
  typedef enum logic {
    ARR_OLDEST_FIRST = 1'b0,
    ARR_NEWEST_FIRST = 1'b1
  } arrange_e;

  // Number of elements presented on the output vector
  function automatic int unsigned out_elems(input int unsigned taps, input bit add_cur);
    return taps + (add_cur ? 1 : 0);
  endfunction

endpackage

// File: rtl/tdl_tap.sv
module tdl_tap #(
  parameter int unsigned       W        = 16,
  parameter logic signed [W-1:0] INIT_VAL = '0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic                adv,
  input  logic signed [W-1:0] d,
  output logic signed [W-1:0] q
);

  logic                ce;
  logic signed [W-1:0] q_nxt;

  // next-state
  always_comb begin
    ce    = load | adv;
    q_nxt = load ? INIT_VAL : d;
  end

  // register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= INIT_VAL;
    end else if (ce) begin
      q <= q_nxt;
    end
  end

  // R2: load writes the initial value regardless of advance
  p_load_init_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (q == INIT_VAL));

  // R3: advance captures the upstream value
  p_advance_take_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load) |=> (q == $past(d)));

  // R4: no load, no advance keeps the stored value
  p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !load) |=> $stable(q));

endmodule

// File: rtl/tdl_chain.sv
module tdl_chain #(
  parameter int unsigned       N        = 4,
  parameter int unsigned       W        = 16,
  parameter logic signed [W-1:0] INIT_VAL = '0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic                  adv,
  input  logic signed [W-1:0]   din,
  output logic [N-1:0][W-1:0]   taps   // taps[k] = delay k+1
);

  logic [N:0][W-1:0] link;

  assign link[0] = din;

  for (genvar k = 0; k < N; k++) begin : g_stage
    logic signed [W-1:0] stage_q;

    tdl_tap #(
      .W        (W),
      .INIT_VAL (INIT_VAL)
    ) u_tap (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (load),
      .adv   (adv),
      .d     (link[k]),
      .q     (stage_q)
    );

    assign link[k+1] = stage_q;
    assign taps[k]   = stage_q;
  end

endmodule

// File: rtl/tdl_arrange.sv
module tdl_arrange #(
  parameter int unsigned        N            = 4,
  parameter int unsigned        W            = 16,
  parameter tdl_pkg::arrange_e  ORDER        = tdl_pkg::ARR_OLDEST_FIRST,
  parameter bit                 ADD_CURRENT  = 1'b0,
  localparam int unsigned       OUT_N        = tdl_pkg::out_elems(N, ADD_CURRENT)
) (
  input  logic [W-1:0]          cur,
  input  logic [N-1:0][W-1:0]   taps,
  output logic [OUT_N*W-1:0]    vec
);

  if (ORDER == tdl_pkg::ARR_OLDEST_FIRST) begin : g_oldest
    // element i <- delay N-i
    for (genvar i = 0; i < N; i++) begin : g_el
      assign vec[i*W +: W] = taps[N-1-i];
    end
    if (ADD_CURRENT) begin : g_cur
      assign vec[N*W +: W] = cur;
    end
  end else begin : g_newest
    localparam int unsigned OFS = ADD_CURRENT ? 1 : 0;
    // element OFS+i <- delay i+1
    for (genvar i = 0; i < N; i++) begin : g_el
      assign vec[(OFS+i)*W +: W] = taps[i];
    end
    if (ADD_CURRENT) begin : g_cur
      assign vec[0 +: W] = cur;
    end
  end

endmodule

// File: rtl/tapped_delay_line.sv
module tapped_delay_line #(
  parameter int unsigned        N            = 4,
  parameter int unsigned        W            = 16,
  parameter int unsigned        CTRL_W       = 2,
  parameter logic signed [W-1:0] INIT_VAL    = '0,
  parameter tdl_pkg::arrange_e  ORDER        = tdl_pkg::ARR_OLDEST_FIRST,
  parameter bit                 ADD_CURRENT  = 1'b0,
  localparam int unsigned       OUT_N        = tdl_pkg::out_elems(N, ADD_CURRENT)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [CTRL_W-1:0]     load_i,
  input  logic [CTRL_W-1:0]     adv_i,
  input  logic signed [W-1:0]   din,
  output logic [OUT_N*W-1:0]    taps_o
);

  logic               load_act;
  logic               adv_act;
  logic [N-1:0][W-1:0] taps;

  // R8: any nonzero control value counts as active
  always_comb begin
    load_act = |load_i;
    adv_act  = |adv_i;
  end

  tdl_chain #(
    .N        (N),
    .W        (W),
    .INIT_VAL (INIT_VAL)
  ) u_chain (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load_act),
    .adv   (adv_act),
    .din   (din),
    .taps  (taps)
  );

  tdl_arrange #(
    .N           (N),
    .W           (W),
    .ORDER       (ORDER),
    .ADD_CURRENT (ADD_CURRENT)
  ) u_arrange (
    .cur  (din),
    .taps (taps),
    .vec  (taps_o)
  );

  // Port-level ordering checks
  if (ORDER == tdl_pkg::ARR_OLDEST_FIRST && N >= 2) begin : g_chk_old
    // R5: after an advance the oldest element is the former second-oldest
    p_oldest_moves_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_act && !load_act) |=> (taps_o[0 +: W] == $past(taps_o[W +: W])));
  end

  if (ORDER == tdl_pkg::ARR_NEWEST_FIRST) begin : g_chk_new
    localparam int unsigned OFS = ADD_CURRENT ? 1 : 0;
    // R6: after an advance the delay-1 element is the sample that was applied
    p_newest_takes_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_act && !load_act) |=> (taps_o[OFS*W +: W] == $past(din)));
  end

endmodule

// File: tb/sim_tapped_delay_line.sv
module sim_tapped_delay_line;

  localparam int unsigned N      = 4;
  localparam int unsigned W      = 16;
  localparam int unsigned CW     = 2;
  localparam logic signed [W-1:0] INIT = 16'shFF3C;   // -196

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CW-1:0] ld = '0;
  logic [CW-1:0] en = '0;
  logic signed [W-1:0] d = '0;

  logic [N*W-1:0]     o0, o1;
  logic [(N+1)*W-1:0] o2, o3;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tapped_delay_line #(.N(N), .W(W), .CTRL_W(CW), .INIT_VAL(INIT),
    .ORDER(tdl_pkg::ARR_OLDEST_FIRST), .ADD_CURRENT(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .load_i(ld), .adv_i(en), .din(d), .taps_o(o0));
  tapped_delay_line #(.N(N), .W(W), .CTRL_W(CW), .INIT_VAL(INIT),
    .ORDER(tdl_pkg::ARR_NEWEST_FIRST), .ADD_CURRENT(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .load_i(ld), .adv_i(en), .din(d), .taps_o(o1));
  tapped_delay_line #(.N(N), .W(W), .CTRL_W(CW), .INIT_VAL(INIT),
    .ORDER(tdl_pkg::ARR_OLDEST_FIRST), .ADD_CURRENT(1'b1)) u2 (
    .clk(clk), .rst_n(rst_n), .load_i(ld), .adv_i(en), .din(d), .taps_o(o2));
  tapped_delay_line #(.N(N), .W(W), .CTRL_W(CW), .INIT_VAL(INIT),
    .ORDER(tdl_pkg::ARR_NEWEST_FIRST), .ADD_CURRENT(1'b1)) u3 (
    .clk(clk), .rst_n(rst_n), .load_i(ld), .adv_i(en), .din(d), .taps_o(o3));

  // Reference history: hq[0] is delay 1, hq[N-1] is delay N
  logic [W-1:0] hq[$];

  function automatic logic [(N+1)*W-1:0] expv(bit newest, bit addcur, logic [W-1:0] cur);
    logic [(N+1)*W-1:0] v = '0;
    int ofs = (newest && addcur) ? 1 : 0;
    for (int i = 0; i < N; i++) begin
      if (newest) v[(ofs+i)*W +: W] = hq[i];
      else        v[i*W +: W]       = hq[N-1-i];
    end
    if (addcur) begin
      if (newest) v[0 +: W] = cur;
      else        v[N*W +: W] = cur;
    end
    return v;
  endfunction

  task automatic cmp(string tag, string req, logic [(N+1)*W-1:0] act, logic [(N+1)*W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, tag, act, exp);
    end
  endtask

  task automatic check_all(string req);
    cmp("oldest", req, {{W{1'b0}}, o0}, expv(1'b0, 1'b0, d));
    cmp("newest", req, {{W{1'b0}}, o1}, expv(1'b1, 1'b0, d));
    cmp("oldest+cur", req, o2, expv(1'b0, 1'b1, d));
    cmp("newest+cur", req, o3, expv(1'b1, 1'b1, d));
  endtask

  // Called just after a falling edge: apply inputs, compare, clock, update model
  task automatic cyc(logic [CW-1:0] l, logic [CW-1:0] e, logic signed [W-1:0] v, string req);
    ld = l; en = e; d = v;
    #1;
    check_all(req);
    @(posedge clk);
    if (l != 0) begin
      for (int i = 0; i < N; i++) hq[i] = INIT;
    end else if (e != 0) begin
      hq.push_front(v);
      void'(hq.pop_back());
    end
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < N; i++) hq.push_back(INIT);
    // R1: state while reset is held
    repeat (3) @(negedge clk);
    #1;
    check_all("R1");
    rst_n = 1'b1;
    // R1 first cycle after release, R4 idle hold
    cyc(2'b00, 2'b00, 16'sd7, "R1");
    cyc(2'b00, 2'b00, 16'sd9, "R4");
    // R3 shifting a ramp, observed in all orders (R5, R6, R7)
    for (int i = 1; i <= 6; i++) cyc(2'b00, 2'b01, W'(i * 17), "R3");
    cyc(2'b00, 2'b00, 16'sd1234, "R5");
    cyc(2'b00, 2'b00, -16'sd5, "R6");
    cyc(2'b00, 2'b00, 16'sd77, "R7");
    // R4: idle hold across several cycles with changing input
    for (int i = 0; i < 4; i++) cyc(2'b00, 2'b00, W'(i * 1001), "R4");
    // R8: upper-bit-only and all-ones advance values
    cyc(2'b00, 2'b10, 16'sd300, "R8");
    cyc(2'b00, 2'b11, 16'sd301, "R8");
    // R9: negative samples
    cyc(2'b00, 2'b01, -16'sd32768, "R9");
    cyc(2'b00, 2'b01, -16'sd1, "R9");
    cyc(2'b00, 2'b01, -16'sd12345, "R9");
    cyc(2'b00, 2'b00, 16'sd0, "R9");
    // R2: load wins over advance; R8: upper-bit-only load
    cyc(2'b01, 2'b01, 16'sd555, "R2");
    cyc(2'b00, 2'b00, 16'sd0, "R2");
    for (int i = 0; i < 3; i++) cyc(2'b00, 2'b01, W'(i + 40), "R3");
    cyc(2'b10, 2'b00, 16'sd99, "R8");
    cyc(2'b00, 2'b00, 16'sd0, "R8");
    // random load / advance mix
    for (int i = 0; i < 400; i++) begin
      logic [CW-1:0] rl = ($urandom % 8 == 0) ? CW'($urandom % 3 + 1) : '0;
      logic [CW-1:0] re = CW'($urandom % 4);
      cyc(rl, re, W'($urandom), "R3");
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule